// File: doc/BRIEF.md
# Synchronous No-Turnaround Static RAM Core

This block models a clocked static RAM whose read and write commands can follow each other on every cycle with no idle slot between them. Commands, addresses, byte enables and write data are all taken on the rising clock edge. Write data is deliberately late: it follows its command by two cycles in pipelined mode and by one cycle in flow-through mode. Because of this, a write's data lands on the data bus in the slot that a read issued after it would have used. The mode comes from a static input that changes only while reset is held. In pipelined mode read data passes through an output register. In flow-through mode it leaves the array directly.

A command cycle either loads a new address or, when the advance input is high, steps a 2-bit burst counter. The counter produces either a linear (wrapping add) sequence or an interleaved (XOR) sequence. A small state machine in the burst controller records what kind of burst is open. It has three states: `BST_IDLE`, `BST_READ` and `BST_WRITE`. A selected read moves it to `BST_READ` and a selected write moves it to `BST_WRITE`. A deselect or a sleep cycle moves it to `BST_IDLE`. An advance cycle leaves it where it is.

Each word holds 9-bit byte lanes, and each lane has its own write enable. A read that hits a write whose data is still in flight receives the merged data. Three chip enables of mixed polarity select the block. An output enable and a sleep input gate the data drivers combinationally.

Top module: `nbt_sram`

## Requirements
- R1: In pipelined mode (`flow_thru`=0), a read taken at clock edge k drives `dq_en`=1 and its data on `dout` between edges k+1 and k+2. A four-beat burst therefore returns data in a 3-1-1-1 pattern.
- R2: In flow-through mode (`flow_thru`=1), a read taken at edge k drives its data between edges k and k+1, which gives a 2-1-1-1 burst.
- R3: The data on `din` for a write taken at edge k is stored at edge k+2 in pipelined mode and at edge k+1 in flow-through mode.
- R4: Reads and writes may alternate on every cycle with no idle cycle, and every read returns the value of the latest earlier write in command order.
- R5: Lane i covers bits 9i+8..9i. A write changes lane i only when `bw_n[i]`=0 in the command cycle. Lanes with `bw_n[i]`=1 keep their old contents.
- R6: A new command is accepted only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise the cycle is a deselect: no write happens and no data is driven.
- R7: `oe_n`=1 forces `dq_en` to 0 at once, without disturbing the read pipeline. A later read slot with `oe_n`=0 drives normally.
- R8: With `adv`=1 the open burst continues and the chip enables are not looked at. The low two address bits become (start+n) mod 4 when `burst_il`=0, or start XOR n when `burst_il`=1, for beat n=1..3. The upper address bits stay fixed. An advance with no open burst does nothing.
- R9: While `sleep`=1, commands are ignored, `dq_en` is 0 and any open burst is closed.
- R10: In pipelined mode, a read issued the cycle after a write to the same address returns the write's data in the lanes it enabled and the array contents in the other lanes.
- R11: An edge with `cke`=0 changes no state. Nothing is written, the command is ignored and pipelined operations resume in order afterwards.
- R12: After reset `dq_en` is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| cke | input | 1 | Clock enable, high to advance |
| flow_thru | input | 1 | 1 = flow-through, 0 = pipelined (static) |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new address |
| we_n | input | 1 | 0 = write command, 1 = read command |
| bw_n | input | LANES | Per-lane write enables, active low |
| adr | input | ADDR_W | Word address |
| burst_il | input | 1 | 1 = interleaved order, 0 = linear |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Power-down request, combinational |
| din | input | LANES*BYTE_W | Late write data |
| dout | output | LANES*BYTE_W | Read data |
| dq_en | output | 1 | High when `dout` should be driven onto the bus |

## Verification
The bench goes after read-after-write in both modes, including a read placed directly behind a partial-lane write. A missing or wrong-lane bypass would return stale bytes, and a write with the wrong lag would store data from the neighbouring bus slot. Every start offset is swept in both burst orders, so a sequence generator that lets the low bits carry into the upper address, or that swaps linear and interleaved order, reads the wrong words. Deselect patterns, sleep and clock-enable stalls are each given a write command that must be dropped, and a later read of that word shows whether it leaked through. Output enable is toggled against a stream of reads to expose an output gate that is registered or that stalls the pipeline.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Kind of burst currently open in the burst controller
    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } burst_state_e;

    // Low two address bits for beat n of a burst that started at 'start'
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ beat;
        else            r = start + beat;
        return r;
    endfunction
endpackage

// File: rtl/nbt_burst_ctl.sv
module nbt_burst_ctl
    import nbt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sleep,
    input  logic              sel,
    input  logic              adv,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] adr,
    input  logic              interleave,
    output logic              acc_vld,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_adr
);
    timeunit 1ns;
    timeprecision 1ps;

    burst_state_e      state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        beat_q, beat_d;
    logic              new_cmd, cont, cont_ok, cont_wr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
        end else if (en) begin
            state_q <= state_d;
            if (new_cmd || cont) begin
                base_q <= base_d;
                beat_q <= beat_d;
            end
        end
    end

    // Next state and access outputs
    always_comb begin
        cont_ok = 1'b0;
        cont_wr = 1'b0;
        unique case (state_q)
            BST_IDLE:  begin cont_ok = 1'b0; cont_wr = 1'b0; end
            BST_READ:  begin cont_ok = 1'b1; cont_wr = 1'b0; end
            BST_WRITE: begin cont_ok = 1'b1; cont_wr = 1'b1; end
            default:   begin cont_ok = 1'b0; cont_wr = 1'b0; end
        endcase

        new_cmd = !sleep && !adv && sel;
        cont    = !sleep && adv && cont_ok;

        state_d = state_q;
        if (sleep)        state_d = BST_IDLE;
        else if (!adv) begin
            if (!sel)     state_d = BST_IDLE;
            else if (we_n) state_d = BST_READ;
            else          state_d = BST_WRITE;
        end

        base_d  = new_cmd ? adr : base_q;
        beat_d  = new_cmd ? 2'd0 : beat_q + 2'd1;
        acc_vld = new_cmd || cont;
        acc_wr  = new_cmd ? !we_n : cont_wr;
        acc_adr = {base_d[ADDR_W-1:2], beat_offset(base_d[1:0], beat_d, interleave)};
    end

    // R9: a sleeping cycle never issues an access
    p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !acc_vld);

    // R8: an accepted advance steps the beat counter by one
    p_beat_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc_vld && adv) |=> (beat_q == $past(beat_q) + 2'd1));

    // R8: an advance never moves the upper address bits
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && adv) |-> (acc_adr[ADDR_W-1:2] == base_q[ADDR_W-1:2]));
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       wadr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       radr,
    output logic [LANES*BYTE_W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[g])
                lane_mem[wadr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[radr];
    end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic                    flow_thru,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       adr,
    input  logic                    burst_il,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [LANES*BYTE_W-1:0] din,
    output logic [LANES*BYTE_W-1:0] dout,
    output logic                    dq_en
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = LANES * BYTE_W;

    logic              sel;
    logic              acc_vld, acc_wr;
    logic [ADDR_W-1:0] acc_adr;

    // Stage 1: access in the cycle after its command
    logic              s1_vld, s1_wr;
    logic [ADDR_W-1:0] s1_adr;
    logic [LANES-1:0]  s1_mask;
    // Stage 2: pipelined write waiting for its data
    logic              s2_vld, s2_wr;
    logic [ADDR_W-1:0] s2_adr;
    logic [LANES-1:0]  s2_mask;

    logic              arr_we;
    logic [ADDR_W-1:0] arr_wadr;
    logic [LANES-1:0]  arr_wmask;
    logic [DW-1:0]     arr_rdata, rd_merged;
    logic              byp_hit;
    logic              o_vld;
    logic [DW-1:0]     o_data;
    logic              rd_live;

    assign sel = !ce1_n && ce2 && !ce3_n;

    nbt_burst_ctl #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cke),
        .sleep      (sleep),
        .sel        (sel),
        .adv        (adv),
        .we_n       (we_n),
        .adr        (adr),
        .interleave (burst_il),
        .acc_vld    (acc_vld),
        .acc_wr     (acc_wr),
        .acc_adr    (acc_adr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_wr   <= 1'b0;
            s1_adr  <= '0;
            s1_mask <= '0;
            s2_vld  <= 1'b0;
            s2_wr   <= 1'b0;
            s2_adr  <= '0;
            s2_mask <= '0;
        end else if (cke) begin
            s1_vld  <= acc_vld;
            s1_wr   <= acc_wr;
            s1_adr  <= acc_adr;
            s1_mask <= ~bw_n;
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_adr  <= s1_adr;
            s2_mask <= s1_mask;
        end
    end

    // Late write: one stage in flow-through, two in pipelined
    always_comb begin
        if (flow_thru) begin
            arr_we    = cke && s1_vld && s1_wr;
            arr_wadr  = s1_adr;
            arr_wmask = s1_mask;
        end else begin
            arr_we    = cke && s2_vld && s2_wr;
            arr_wadr  = s2_adr;
            arr_wmask = s2_mask;
        end
    end

    nbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .wadr  (arr_wadr),
        .wmask (arr_wmask),
        .wdata (din),
        .radr  (s1_adr),
        .rdata (arr_rdata)
    );

    // Read hits the pipelined write whose data is on din right now
    assign byp_hit = !flow_thru && s2_vld && s2_wr && (s2_adr == s1_adr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign rd_merged[g*BYTE_W +: BYTE_W] = (byp_hit && s2_mask[g])
            ? din[g*BYTE_W +: BYTE_W] : arr_rdata[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_data <= '0;
        end else if (cke) begin
            o_vld  <= s1_vld && !s1_wr;
            o_data <= rd_merged;
        end
    end

    assign rd_live = flow_thru ? (s1_vld && !s1_wr) : o_vld;
    assign dout    = flow_thru ? rd_merged : o_data;
    assign dq_en   = rd_live && !oe_n && !sleep;

    // R11: a disabled edge leaves the pipeline untouched
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(s1_vld) && $stable(s1_adr) && $stable(s2_vld)
                  && $stable(s2_adr) && $stable(o_vld)));

    // R3: the pending write moves one stage per enabled edge
    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> ((s2_vld == $past(s1_vld)) && (s2_adr == $past(s1_adr))));

    // R6: a deselect command creates no access
    p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !sel && !adv) |=> !s1_vld);
endmodule

// File: tb/nbt_sram_test.sv
module nbt_sram_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 4;
    localparam int NL = 2;
    localparam int BW = 9;
    localparam int DW = NL * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic          flow_thru = 1'b0;
    logic          ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adv = 1'b0, we_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] adr = '0;
    logic          burst_il = 1'b0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dq_en;

    nbt_sram #(.ADDR_W(AW), .LANES(NL), .BYTE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .flow_thru(flow_thru),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .adr(adr), .burst_il(burst_il), .oe_n(oe_n),
        .sleep(sleep), .din(din), .dout(dout), .dq_en(dq_en)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Expected-read ring and late-write-data ring, indexed by cycle
    bit          exp_on [8];
    logic [DW-1:0] exp_dat [8];
    string       exp_tag [8];
    bit          ws_on [8];
    logic [DW-1:0] ws_dat [8];
    logic [DW-1:0] shadow [1 << AW];
    int          cyc = 0;
    int          b_state = 0;       // 0 none, 1 read burst, 2 write burst
    int          b_base = 0;
    int          b_beat = 0;

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic check(input string tag, input bit ok, input logic [DW:0] act, input logic [DW:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'(a * 2731 + k * 40503 + 77);
    endfunction

    // kinds: 0 idle, 1 read, 2 write, 3 advance, 4..6 write with one enable off
    task automatic step(input int kind, input int a, input logic [NL-1:0] mn,
                        input logic [DW-1:0] wd, input string tag,
                        input bit oe_off = 0, input bit slp = 0);
        int eff;
        int op;     // 0 none, 1 read, 2 write
        int slot;
        bit exp_en;
        op = 0;
        eff = a;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adv = 1'b0; we_n = 1'b1; bw_n = mn;
        adr = AW'(a);
        oe_n = oe_off; sleep = slp;
        din = ws_on[cyc % 8] ? ws_dat[cyc % 8] : '0;
        ws_on[cyc % 8] = 0;
        case (kind)
            0: ce1_n = 1'b1;
            1: we_n = 1'b1;
            2: we_n = 1'b0;
            3: begin adv = 1'b1; ce1_n = 1'b1; end
            4: begin we_n = 1'b0; ce1_n = 1'b1; end
            5: begin we_n = 1'b0; ce2 = 1'b0; end
            default: begin we_n = 1'b0; ce3_n = 1'b1; end
        endcase
        // Model from the requirements
        if (slp) b_state = 0;
        else if (kind == 1) begin b_state = 1; b_base = a; b_beat = 0; op = 1; end
        else if (kind == 2) begin b_state = 2; b_base = a; b_beat = 0; op = 2; end
        else if (kind == 3) begin
            if (b_state != 0) begin
                b_beat = (b_beat + 1) % 4;
                eff = (b_base & ~3) | (burst_il ? ((b_base & 3) ^ b_beat)
                                                : (((b_base & 3) + b_beat) % 4));
                op = b_state;
            end
        end else b_state = 0;
        if (op == 1) begin
            slot = (cyc + (flow_thru ? 0 : 1)) % 8;
            exp_on[slot] = 1; exp_dat[slot] = shadow[eff]; exp_tag[slot] = tag;
        end else if (op == 2) begin
            slot = (cyc + (flow_thru ? 1 : 2)) % 8;
            ws_on[slot] = 1; ws_dat[slot] = wd;
            for (int l = 0; l < NL; l++)
                if (!mn[l]) shadow[eff][l*BW +: BW] = wd[l*BW +: BW];
        end
        @(posedge clk);
        @(negedge clk);
        slot = cyc % 8;
        exp_en = exp_on[slot] && !oe_off && !slp;
        check(exp_on[slot] ? exp_tag[slot] : tag, dq_en === exp_en,
              {dq_en, dout}, {exp_en, exp_dat[slot]});
        if (exp_en)
            check(exp_tag[slot], dout === exp_dat[slot], {1'b0, dout}, {1'b0, exp_dat[slot]});
        exp_on[slot] = 0;
        cyc++;
    endtask

    task automatic stall(input int n);
        for (int i = 0; i < n; i++) begin
            cke = 1'b0;
            ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
            adv = 1'b0; we_n = 1'b0; bw_n = '0; adr = AW'(6);
            din = ws_on[cyc % 8] ? ws_dat[cyc % 8] : '1;
            @(posedge clk);
            @(negedge clk);
        end
        cke = 1'b1;
    endtask

    task automatic do_reset(input bit flow);
        rst_n = 1'b0;
        flow_thru = flow;
        ce1_n = 1'b1; adv = 1'b0; oe_n = 1'b0; sleep = 1'b0; cke = 1'b1;
        for (int i = 0; i < 8; i++) begin exp_on[i] = 0; ws_on[i] = 0; end
        b_state = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", dq_en === 1'b0, {dq_en, dout}, '0);
        // R12: no burst open, so an advance right after reset does nothing
        step(3, 0, 2'b00, '0, "R12");
    endtask

    task automatic suite(input bit flow, input int salt);
        string rt;
        rt = flow ? "R2" : "R1";
        do_reset(flow);
        // R3: fill every word
        for (int a = 0; a < 16; a++) step(2, a, 2'b00, pat(a, salt), "R3");
        for (int a = 0; a < 16; a++) step(1, a, 2'b11, '0, rt);
        // R4 R5 R10: write-read-read alternation with every lane mask
        for (int a = 0; a < 16; a++) begin
            step(2, a, 2'(a % 4), pat(a, salt + 1), "R5");
            step(1, a, 2'b11, '0, flow ? "R4" : "R10");
            step(2, (a + 3) % 16, 2'b00, pat(a, salt + 2), "R4");
            step(1, (a + 1) % 16, 2'b11, '0, "R4");
        end
        // R8: every start offset, both orders, read and write bursts
        for (int il = 0; il < 2; il++) begin
            burst_il = il[0];
            for (int s = 0; s < 4; s++) begin
                step(1, 8 + s, 2'b11, '0, "R8");
                for (int b = 0; b < 3; b++) step(3, 0, 2'b11, '0, "R8");
                step(2, 4 + s, 2'b00, pat(s, salt + 3), "R8");
                for (int b = 0; b < 3; b++) step(3, 0, 2'(b), pat(b, salt + s), "R8");
                step(1, 4 + s, 2'b11, '0, "R8");
                for (int b = 0; b < 3; b++) step(3, 0, 2'b11, '0, "R8");
            end
        end
        burst_il = 1'b0;
        step(0, 0, 2'b11, '0, "R8");
        step(3, 0, 2'b00, '0, "R8");
        // R6: each enable off, write must be dropped
        for (int k = 4; k <= 6; k++) step(k, 2, 2'b00, pat(k, 9), "R6");
        step(0, 0, 2'b11, '0, "R6");
        step(0, 0, 2'b11, '0, "R6");
        step(1, 2, 2'b11, '0, "R6");
        step(0, 0, 2'b11, '0, "R6");
        // R7: output enable toggled over a read stream
        for (int i = 0; i < 8; i++) step(1, i, 2'b11, '0, "R7", i[0]);
        step(0, 0, 2'b11, '0, "R7");
        step(0, 0, 2'b11, '0, "R7", 1'b1);
        // R9: sleep drops a write, a read and closes a burst
        step(2, 7, 2'b00, pat(7, 99), "R9", 1'b0, 1'b1);
        step(1, 7, 2'b11, '0, "R9", 1'b0, 1'b1);
        step(0, 0, 2'b11, '0, "R9");
        step(0, 0, 2'b11, '0, "R9");
        step(1, 7, 2'b11, '0, "R9");
        step(1, 9, 2'b11, '0, "R9");
        step(3, 0, 2'b11, '0, "R9", 1'b0, 1'b1);
        step(3, 0, 2'b11, '0, "R9");
        step(0, 0, 2'b11, '0, "R9");
        // R11: stalls around a late write and a read
        step(2, 5, 2'b00, pat(5, salt + 7), "R11");
        stall(3);
        step(1, 3, 2'b11, '0, "R11");
        stall(2);
        step(0, 0, 2'b11, '0, "R11");
        step(0, 0, 2'b11, '0, "R11");
        step(1, 5, 2'b11, '0, "R11");
        step(1, 6, 2'b11, '0, "R11");
        step(0, 0, 2'b11, '0, "R11");
        step(0, 0, 2'b11, '0, "R11");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        suite(1'b0, 1);
        suite(1'b1, 5);
        suite(1'b0, 11);
        report();
    end
endmodule